// File: doc/BRIEF.md
# Grouped Prescaler and Per-Channel Power-of-Two Tick Generator

This block produces count-enable strobes for a bank of five timer channels. All of them run from one peripheral clock. There are two 8-bit prescalers, and both are set from a single 16-bit configuration word. The first prescaler serves channels 0 and 1. The second serves channels 2, 3 and 4. After its shared prescaler, each channel applies a power-of-two divider of its own. The divider is picked by a 4-bit code in a second configuration word.

The outputs are single-cycle enables in the input clock domain, not derived clocks. A timer counter advances on each strobe. Both configuration words are plain inputs, held by whatever register logic sits outside.

The divider code is offset by a base parameter. With base 1, code 0 divides by 2. With base 0, code 0 divides by 1. Any code past divide-by-16 is treated as divide-by-16. When a prescaler value changes, that prescaler restarts, and so do all dividers in its group. When a channel's divider code changes, only that channel restarts. Each change therefore gives a clean first period.

Top module: `tick_divider_bank`

## Requirements
- R1: While rst_n is low, every tick_en bit is 0.
- R2: Channels 0 and 1 take their prescaler value N0 from pre_cfg[7:0]. The prescaler divides by N0+1.
- R3: Channels 2, 3 and 4 take their prescaler value N1 from pre_cfg[15:8]. The prescaler divides by N1+1.
- R4: Channel c reads its divider code s from sel_cfg[4c+3:4c]. The divide ratio is 2^(s+DIV_BASE). With the default DIV_BASE=1, code 0 gives ÷2, code 1 gives ÷4, code 2 gives ÷8 and code 3 gives ÷16.
- R5: Any code where s+DIV_BASE exceeds 4 gives ÷16. With the default base, this covers codes 4 to 15.
- R6: Once the configuration is stable, channel c pulses every P = (N+1)·2^L clock cycles. N is the value of the channel's prescaler and L is its clamped log2 ratio.
- R7: With DIV_BASE=1, no tick_en bit is high in two consecutive cycles.
- R8: In a cycle where a prescaler value differs from its value in the previous cycle, that group's channels do not tick. The prescaler and all dividers in the group restart. The first tick is sampled exactly P cycles after the new value is applied.
- R9: In a cycle where a channel's divider code changes, that channel does not tick, and its divider restarts. Other channels keep their phase and period.
- R10: Channels of the same group with equal divider codes tick in the same cycles after a restart of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_cfg | input | 16 | Two prescaler values, each stored as ratio minus one: group 0 in [7:0], group 1 in [15:8] |
| sel_cfg | input | 20 | Divider codes, 4 bits per channel at offset 4·channel |
| tick_en | output | 5 | One single-cycle count-enable strobe per channel |

## Verification
The bench checks three timing corner cases.

The first is the latency from a configuration change to the first tick. A design that failed to clear the group's dividers on a prescaler change would deliver its first tick early, by the stale divider phase.

The second is the field layout. Swapping the two prescaler bytes, or misplacing a 4-bit code, shows up as a wrong period on a specific channel.

The third is the clamp for oversized codes. A design that wrapped the shift instead of saturating it would produce a short period for code 9.

The bench also changes one channel's code while it times a neighbour. A restart that leaked across channels would stretch the neighbour's interval.

// File: rtl/tick_divider_bank.sv
module tick_divider_bank #(
  parameter int NCH      = 5,
  parameter int PW       = 8,
  parameter int SELW     = 4,
  parameter int DIV_BASE = 1,
  parameter int MAXLOG   = 4,
  parameter int SPLIT    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*PW-1:0]      pre_cfg,
  input  logic [NCH*SELW-1:0]  sel_cfg,
  output logic [NCH-1:0]       tick_en
);
  localparam int NGRP = 2;
  localparam int LW   = SELW + 1;

  logic [NGRP-1:0] pre_rst, pre_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    logic [PW-1:0] val, val_q, cnt;
    assign val = pre_cfg[g*PW +: PW];
    assign pre_rst[g] = (val != val_q);
    assign pre_hit[g] = !pre_rst[g] && (cnt == val_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        cnt   <= '0;
      end else begin
        val_q <= val;
        if (pre_rst[g] || pre_hit[g]) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G = (c < SPLIT) ? 0 : 1;
    logic [SELW-1:0]   sel, sel_q;
    logic [LW-1:0]     lg_raw, lg;
    logic [MAXLOG-1:0] mask, dcnt;
    logic              sel_rst, last;

    assign sel     = sel_cfg[c*SELW +: SELW];
    assign sel_rst = (sel != sel_q);
    assign lg_raw  = LW'(sel) + LW'(DIV_BASE);
    assign lg      = (lg_raw > LW'(MAXLOG)) ? LW'(MAXLOG) : lg_raw;
    assign mask    = ~({MAXLOG{1'b1}} << lg);
    assign last    = &(dcnt | ~mask);
    assign tick_en[c] = pre_hit[G] && last && !sel_rst;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        dcnt  <= '0;
      end else begin
        sel_q <= sel;
        if (sel_rst || pre_rst[G]) dcnt <= '0;
        else if (pre_hit[G])       dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_divider_bank_chk.sv
module tick_divider_bank_chk #(
  parameter int NCH      = 5,
  parameter int PW       = 8,
  parameter int SELW     = 4,
  parameter int DIV_BASE = 1,
  parameter int SPLIT    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*PW-1:0]     pre_cfg,
  input logic [NCH*SELW-1:0] sel_cfg,
  input logic [NCH-1:0]      tick_en
);
  logic [1:0] up;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up <= '0;
    else if (up != 2'd2) up <= up + 2'd1;
  wire armed = (up == 2'd2);

  // R1
  always @(negedge clk) if (!rst_n) reset_quiet_chk: assert (tick_en == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam int G = (c < SPLIT) ? 0 : 1;
    // R8
    pre_restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$stable(pre_cfg[G*PW +: PW])) |-> !tick_en[c]);
    // R9
    sel_restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$stable(sel_cfg[c*SELW +: SELW])) |-> !tick_en[c]);
    if (DIV_BASE >= 1) begin : g_single
      // R7
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en[c] |=> !tick_en[c]);
    end
  end
endmodule

bind tick_divider_bank tick_divider_bank_chk #(
  .NCH(NCH), .PW(PW), .SELW(SELW), .DIV_BASE(DIV_BASE), .SPLIT(SPLIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pre_cfg(pre_cfg), .sel_cfg(sel_cfg), .tick_en(tick_en)
);

// File: tb/test_tick_divider_bank.sv
`timescale 1ns/1ps
module test_tick_divider_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pre_cfg = '0;
  logic [19:0] sel_cfg = '0;
  logic [4:0]  tick_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_divider_bank i_tick_divider_bank (
    .clk(clk), .rst_n(rst_n), .pre_cfg(pre_cfg), .sel_cfg(sel_cfg), .tick_en(tick_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sel(input int ch, input logic [3:0] code);
    sel_cfg[ch*4 +: 4] = code;
  endtask

  task automatic wait_tick(input int ch, output bit ok);
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (tick_en[ch]) begin ok = 1; break; end
    end
  endtask

  task automatic measure(input int ch, input int exp, input string req);
    bit ok;
    int n;
    wait_tick(ch, ok);
    n = 0;
    if (ok) begin
      ok = 0;
      for (int k = 0; k < 20000; k++) begin
        @(negedge clk); n++;
        if (tick_en[ch]) begin ok = 1; break; end
      end
    end
    check(ok && n == exp, req, n, exp);
  endtask

  task automatic latency(input int ch, input int exp, input string req);
    int n = 0;
    bit ok = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); n++;
      if (tick_en[ch]) begin ok = 1; break; end
    end
    check(ok && n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tick_en == 5'd0, "R1 reset", tick_en, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_group0;
    @(negedge clk);
    pre_cfg[7:0] = 8'd3; set_sel(0, 4'd1); set_sel(1, 4'd0);
    measure(0, 16, "R2 R4 R6 ch0 pre3 code1");
    measure(1, 8, "R2 R4 ch1 pre3 code0");
  endtask

  task automatic t_group1;
    @(negedge clk);
    pre_cfg[15:8] = 8'd4; set_sel(2, 4'd2); set_sel(3, 4'd0); set_sel(4, 4'd3);
    measure(2, 40, "R3 R6 ch2 pre4 code2");
    measure(3, 10, "R3 R4 ch3 pre4 code0");
    measure(4, 80, "R3 R4 ch4 pre4 code3");
    measure(0, 16, "R2 ch0 unaffected by group1");
  endtask

  task automatic t_clamp;
    @(negedge clk); set_sel(4, 4'd9);
    measure(4, 80, "R5 code9 clamps to div16");
    @(negedge clk); set_sel(4, 4'd15);
    measure(4, 80, "R5 code15 clamps to div16");
  endtask

  task automatic t_restart;
    @(negedge clk); pre_cfg[15:8] = 8'd2;
    latency(3, 6, "R8 ch3 first tick after pre1 change");
    @(negedge clk); pre_cfg[15:8] = 8'd1;
    latency(4, 32, "R8 ch4 first tick after pre1 change");
    @(negedge clk); pre_cfg[7:0] = 8'd2;
    latency(0, 12, "R8 ch0 first tick after pre0 change");
  endtask

  task automatic t_isolation;
    bit ok;
    int n = 0;
    set_sel(0, 4'd1); set_sel(1, 4'd1);
    wait_tick(1, ok);
    set_sel(0, 4'd3);
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); n++;
      if (tick_en[1]) begin ok = 1; break; end
    end
    check(ok && n == 12, "R9 ch1 interval across ch0 code change", n, 12);
    measure(0, 48, "R9 ch0 new code period");
  endtask

  task automatic t_align;
    int mism = 0, dbl = 0, seen = 0;
    bit prev = 0;
    @(negedge clk); set_sel(0, 4'd2); set_sel(1, 4'd2); pre_cfg[7:0] = 8'd1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (tick_en[0] != tick_en[1]) mism++;
      if (tick_en[0] && prev) dbl++;
      if (tick_en[0]) seen++;
      prev = tick_en[0];
    end
    check(mism == 0, "R10 ch0 ch1 aligned", mism, 0);
    check(seen == 25, "R10 R6 tick count in 400 cycles", seen, 25);
    check(dbl == 0, "R7 no back-to-back ticks", dbl, 0);
  endtask

  initial begin
    t_reset();
    t_group0();
    t_group1();
    t_clamp();
    t_restart();
    t_isolation();
    t_align();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule